// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block is the digital controller that sits next to a successive-approximation converter. It decides when acquisition of the analog input stops and conversion starts. It steps the converter through its bit decisions on a programmable conversion clock, and it places each finished code in a result register together with a single-cycle done pulse. The comparator and the sample-and-hold stay outside the block. The block drives a trial code towards the analog core and reads back a single comparator bit.

The block runs on a clock at twice the instruction rate. Each conversion-clock period is therefore a whole number of these clock cycles. A 3-bit selector picks how a conversion is started:
- under software control, by clearing the sample request;
- from a timer event or an external event, each synchronised and edge-detected inside the block;
- by an automatic mode that counts conversion-clock periods of acquisition and then re-arms itself after every result.

Dropping the enable aborts the sequence and leaves the result register untouched. A short lockout then keeps a new sample request from taking effect too early.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `result` is 0, `result_done` is 0 and `dac_code` is 0.
- R2: `ctl_trig_sel` encodes the start source: 3'b000 software, 3'b001 timer event, 3'b010 external event, 3'b111 automatic. Codes 3'b011 to 3'b110 never start a conversion, so no done pulse follows and `result` keeps its value.
- R3: In software mode, a rising edge of `ctl_sample` with `ctl_enable` high starts acquisition. The falling edge of `ctl_sample` starts conversion at the clock edge where it is seen. `result_done` rises 14 conversion-clock periods after that edge.
- R4: One conversion-clock period lasts `ctl_clk_div`+1 cycles of `clk`, for every code from 0 to 63.
- R5: The conversion makes 12 decisions, MSB first. In each decision, `cmp_in`=1 means that the analog input is at or above `dac_code`, and the trial bit is kept. The final `result` is the analog level the comparator reports.
- R6: In automatic mode, acquisition lasts `ctl_acq_count` conversion-clock periods, and a count of 0 acts as 1. Acquisition restarts as soon as a result is written, so successive done pulses are (count+14)·(`ctl_clk_div`+1) cycles apart.
- R7: Timer and external events pass two synchroniser stages and an edge detector. Conversion starts 3 clock edges after the event is first high. An event that arrives during a conversion is ignored and does not shift the result time.
- R8: Clearing `ctl_enable` during acquisition or conversion aborts it. No done pulse follows and `result` keeps the last completed value.
- R9: If `ctl_enable` is cleared at the very edge where automatic mode would start a conversion, no conversion starts.
- R10: After an abort, a rising edge of `ctl_sample` that is seen within 2 conversion-clock periods of the abort edge, the boundary edge included, is ignored. A rising edge one cycle later starts acquisition.
- R11: `result_done` is a one-cycle pulse, and `result` changes only in the cycle in which `result_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the instruction rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Converter enable; clearing it aborts |
| ctl_sample | input | 1 | Sample request; rising edge starts acquisition, falling edge starts conversion in software mode |
| ctl_trig_sel | input | 3 | Start-source selector |
| ctl_acq_count | input | 5 | Acquisition length in conversion-clock periods (automatic mode) |
| ctl_clk_div | input | 6 | Conversion-clock divider code |
| timer_evt | input | 1 | Timer start event, asynchronous |
| ext_evt | input | 1 | External start event, asynchronous |
| cmp_in | input | 1 | Comparator decision from the analog core |
| dac_code | output | 12 | Trial code for the analog core |
| result | output | 12 | Last completed conversion |
| result_done | output | 1 | One-cycle pulse when `result` is written |

## Verification
The bench builds the block with its defaults: 12 result bits, a 6-bit divider, a 5-bit acquisition count, two synchroniser stages and a 2-period lockout. The 6-bit divider lets the bench measure exact latencies at both ends of the range, at codes 0 and 63, with the slowest conversion still under a thousand cycles. The two-stage synchroniser fixes the event-to-conversion delay at 3 edges, which the bench checks cycle-exactly. The 2-period lockout is short enough to probe its boundary edge and the edge just after it at a small divider code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int TSEL_W = 3;

   localparam logic [TSEL_W-1:0] TS_SOFT  = 3'b000;
   localparam logic [TSEL_W-1:0] TS_TIMER = 3'b001;
   localparam logic [TSEL_W-1:0] TS_EXT   = 3'b010;
   localparam logic [TSEL_W-1:0] TS_AUTO  = 3'b111;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACQ,
      ST_CONV,
      ST_LOCK
   } seq_state_t;

endpackage

// File: rtl/adc_tad_gen.sv
// Conversion-clock divider: one tick every div_code+1 cycles, phase-aligned by restart.
module adc_tad_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_code,
   output logic             tick
);

   localparam logic [DIV_W-1:0] ONE_D = 1;

   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == div_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE_D;
      end
   end

endmodule

// File: rtl/adc_trig_sync.sv
// Synchroniser chain followed by a rising-edge detector.
module adc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-1:0], async_in};
      end
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/adc_sar_core.sv
// Step sequencer and approximation register: one setup step, BITS decisions, one write step.
module adc_sar_core #(
   parameter int BITS = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            run,
   input  logic            tick,
   input  logic            cmp_in,
   output logic [BITS-1:0] dac_code,
   output logic [BITS-1:0] value,
   output logic            last
);

   localparam int STEPS = BITS + 2;
   localparam int SW    = $clog2(STEPS);
   localparam logic [SW-1:0] ONE_S   = 1;
   localparam logic [SW-1:0] FIRST_D = 1;
   localparam logic [SW-1:0] LAST_D  = SW'(BITS);
   localparam logic [SW-1:0] LAST_S  = SW'(STEPS - 1);
   localparam logic [BITS-1:0] LSB   = 1;

   logic [SW-1:0]   step_q;
   logic [BITS-1:0] sar_q;
   logic [BITS-1:0] trial;
   logic            decide;

   assign decide = run && (step_q >= FIRST_D) && (step_q <= LAST_D);

   always_comb begin
      trial = '0;
      if (decide) begin
         trial = LSB << (BITS - int'(step_q));
      end
   end

   assign dac_code = sar_q | trial;
   assign value    = sar_q;
   assign last     = run && tick && (step_q == LAST_S);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         sar_q  <= '0;
      end else if (start) begin
         step_q <= '0;
         sar_q  <= '0;
      end else if (run && tick) begin
         step_q <= step_q + ONE_S;
         if (decide && cmp_in) begin
            sar_q <= sar_q | trial;
         end
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int ADC_BITS    = 12,
   parameter int DIV_W       = 6,
   parameter int ACQ_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_TADS   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_enable,
   input  logic                ctl_sample,
   input  logic [TSEL_W-1:0]   ctl_trig_sel,
   input  logic [ACQ_W-1:0]    ctl_acq_count,
   input  logic [DIV_W-1:0]    ctl_clk_div,
   input  logic                timer_evt,
   input  logic                ext_evt,
   input  logic                cmp_in,
   output logic [ADC_BITS-1:0] dac_code,
   output logic [ADC_BITS-1:0] result,
   output logic                result_done
);

   localparam int NUM_EVT = 2;
   localparam logic [ACQ_W-1:0] ONE_A     = 1;
   localparam logic [ACQ_W-1:0] LOCK_LAST = ACQ_W'(LOCK_TADS - 1);

   // elaboration-time parameter checks
   if (ADC_BITS < 2 || ADC_BITS > 16) begin : g_bad_bits
      $error("ADC_BITS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOCK_TADS < 1 || LOCK_TADS > (1 << ACQ_W)) begin : g_bad_lock
      $error("LOCK_TADS does not fit the phase counter");
   end
   if (DIV_W < 1 || ACQ_W < 1) begin : g_bad_width
      $error("counter widths must be positive");
   end

   seq_state_t state_q, state_d;
   logic [ACQ_W-1:0] ph_q;
   logic [ACQ_W-1:0] acq_eff;
   logic             sample_q;
   logic             smp_rise, smp_fall;
   logic             tick, restart, conv_start, conv_last;
   logic [ADC_BITS-1:0] sar_value;
   logic [NUM_EVT-1:0]  evt_raw, evt_rise;
   logic [ADC_BITS-1:0] result_q;
   logic                done_q;

   // event synchronisers, one per external source (0 timer, 1 external)
   assign evt_raw = {ext_evt, timer_evt};
   for (genvar g = 0; g < NUM_EVT; g++) begin : g_sync
      adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (evt_raw[g]),
         .rise     (evt_rise[g])
      );
   end

   adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .div_code (ctl_clk_div),
      .tick     (tick)
   );

   adc_sar_core #(.BITS(ADC_BITS)) u_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (conv_start),
      .run      (state_q == ST_CONV),
      .tick     (tick),
      .cmp_in   (cmp_in),
      .dac_code (dac_code),
      .value    (sar_value),
      .last     (conv_last)
   );

   assign smp_rise = ctl_sample & ~sample_q;
   assign smp_fall = ~ctl_sample & sample_q;
   assign acq_eff  = (ctl_acq_count == '0) ? ONE_A : ctl_acq_count;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (ctl_enable && smp_rise) state_d = ST_ACQ;
         end
         ST_ACQ: begin
            if (!ctl_enable) begin
               state_d = ST_LOCK;
            end else begin
               unique case (ctl_trig_sel)
                  TS_SOFT:  if (smp_fall)    state_d = ST_CONV;
                  TS_TIMER: if (evt_rise[0]) state_d = ST_CONV;
                  TS_EXT:   if (evt_rise[1]) state_d = ST_CONV;
                  TS_AUTO:  if (tick && ph_q == (acq_eff - ONE_A)) state_d = ST_CONV;
                  default:  state_d = ST_ACQ;
               endcase
            end
         end
         ST_CONV: begin
            if (!ctl_enable) begin
               state_d = ST_LOCK;
            end else if (conv_last) begin
               state_d = (ctl_trig_sel == TS_AUTO) ? ST_ACQ : ST_IDLE;
            end
         end
         ST_LOCK: begin
            if (tick && ph_q == LOCK_LAST) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign restart    = (state_d != state_q);
   assign conv_start = (state_d == ST_CONV) && (state_q != ST_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ph_q     <= '0;
         sample_q <= 1'b0;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         sample_q <= ctl_sample;
         if (restart) begin
            ph_q <= '0;
         end else if (tick) begin
            ph_q <= ph_q + ONE_A;
         end
         done_q <= (state_q == ST_CONV) && ctl_enable && conv_last;
         if ((state_q == ST_CONV) && ctl_enable && conv_last) begin
            result_q <= sar_value;
         end
      end
   end

   assign result      = result_q;
   assign result_done = done_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
#(
   parameter int BITS = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ctl_enable,
   input logic [BITS-1:0] result,
   input logic            result_done,
   input seq_state_t      state_q,
   input logic            conv_last
);

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      result_done |=> !result_done);

   p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> result_done);

   p_done_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      result_done |-> ($past(state_q) == ST_CONV));

   p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |=> !result_done);

   p_lock_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK) |=> (state_q == ST_LOCK || state_q == ST_IDLE));

   p_conv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && ctl_enable && !conv_last) |=> (state_q == ST_CONV));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.BITS(ADC_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_enable  (ctl_enable),
   .result      (result),
   .result_done (result_done),
   .state_q     (state_q),
   .conv_last   (conv_last)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_enable = 1'b0;
   logic        ctl_sample = 1'b0;
   logic [2:0]  ctl_trig_sel = 3'b000;
   logic [4:0]  ctl_acq_count = 5'd1;
   logic [5:0]  ctl_clk_div = 6'd0;
   logic        timer_evt = 1'b0;
   logic        ext_evt = 1'b0;
   logic        cmp_in;
   logic [11:0] dac_code;
   logic [11:0] result;
   logic        result_done;
   logic [11:0] vin = 12'h000;

   int checks = 0;
   int errors = 0;
   logic [11:0] last_res = 12'h000;

   always #2 clk = ~clk;

   // comparator model: high when the analog level is at or above the trial code
   assign cmp_in = (vin >= dac_code);

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_enable    (ctl_enable),
      .ctl_sample    (ctl_sample),
      .ctl_trig_sel  (ctl_trig_sel),
      .ctl_acq_count (ctl_acq_count),
      .ctl_clk_div   (ctl_clk_div),
      .timer_evt     (timer_evt),
      .ext_evt       (ext_evt),
      .cmp_in        (cmp_in),
      .dac_code      (dac_code),
      .result        (result),
      .result_done   (result_done)
   );

   // {divider code, analog level}
   localparam logic [17:0] VEC [6] = '{
      {6'd0, 12'h000}, {6'd0, 12'hFFF}, {6'd1, 12'hA5A},
      {6'd3, 12'h001}, {6'd7, 12'h800}, {6'd2, 12'h7FF}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!result_done && lat < 3000);
   endtask

   task automatic count_done(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (result_done) cnt++;
      end
   endtask

   task automatic run_sw(input logic [5:0] div, input logic [11:0] v, output int lat);
      ctl_trig_sel = 3'b000;
      ctl_clk_div  = div;
      vin          = v;
      @(negedge clk) ctl_sample = 1'b1;
      @(negedge clk) ctl_sample = 1'b0;
      wait_done(lat);
   endtask

   // software start, abort 10 cycles into conversion; returns right after driving enable low
   task automatic start_and_abort(input logic [11:0] v);
      ctl_trig_sel = 3'b000;
      ctl_clk_div  = 6'd1;
      vin          = v;
      @(negedge clk) ctl_sample = 1'b1;
      @(negedge clk) ctl_sample = 1'b0;
      repeat (10) @(negedge clk);
      ctl_enable = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lat, cnt;
      repeat (3) @(negedge clk);
      chk(result == 12'h000, "R1 result in reset", int'(result), 0);
      chk(result_done == 1'b0, "R1 done in reset", int'(result_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dac_code == 12'h000, "R1 dac after reset", int'(dac_code), 0);
      ctl_enable = 1'b1;

      // table of software conversions: result value and latency
      for (int i = 0; i < 6; i++) begin
         logic [5:0]  d;
         logic [11:0] v;
         d = VEC[i][17:12];
         v = VEC[i][11:0];
         run_sw(d, v, lat);
         chk(result == v, "R5 sw result", int'(result), int'(v));
         chk(lat == 14 * (int'(d) + 1) + 1, "R3 R4 sw latency", lat, 14 * (int'(d) + 1) + 1);
         last_res = v;
      end

      // largest divider code
      run_sw(6'd63, 12'h3C3, lat);
      chk(result == 12'h3C3, "R5 result at div 63", int'(result), 'h3C3);
      chk(lat == 14 * 64 + 1, "R4 latency at div 63", lat, 14 * 64 + 1);
      last_res = 12'h3C3;

      // automatic mode, count 4, divider 2
      ctl_trig_sel = 3'b111; ctl_acq_count = 5'd4; ctl_clk_div = 6'd2; vin = 12'h5C1;
      @(negedge clk) ctl_sample = 1'b1;
      wait_done(lat);
      wait_done(lat);
      chk(lat == 18 * 3, "R6 auto period", lat, 54);
      chk(result == 12'h5C1, "R6 auto result", int'(result), 'h5C1);
      @(negedge clk) begin ctl_enable = 1'b0; ctl_sample = 1'b0; end
      repeat (10) @(negedge clk);
      ctl_enable = 1'b1;

      // automatic mode, count 0 acts as 1, divider 1
      ctl_acq_count = 5'd0; ctl_clk_div = 6'd1; vin = 12'h0F0;
      @(negedge clk) ctl_sample = 1'b1;
      wait_done(lat);
      wait_done(lat);
      chk(lat == 15 * 2, "R6 auto count zero period", lat, 30);
      @(negedge clk) begin ctl_enable = 1'b0; ctl_sample = 1'b0; end
      repeat (10) @(negedge clk);
      ctl_enable = 1'b1;
      last_res = 12'h0F0;

      // enable cleared exactly at the automatic start edge (count 3, divider 1 -> edge S+6)
      ctl_acq_count = 5'd3; ctl_clk_div = 6'd1; vin = 12'hABC;
      @(negedge clk) ctl_sample = 1'b1;
      repeat (6) @(negedge clk);
      ctl_enable = 1'b0;
      count_done(80, cnt);
      chk(cnt == 0, "R9 no conversion after coincident clear", cnt, 0);
      chk(result == last_res, "R9 result kept", int'(result), int'(last_res));
      ctl_sample = 1'b0;
      repeat (4) @(negedge clk);
      ctl_enable = 1'b1;

      // abort during conversion, then a rise on the lockout boundary edge
      start_and_abort(12'h123);
      @(negedge clk) ctl_enable = 1'b1;     // k=1
      repeat (3) @(negedge clk);            // k=4
      ctl_sample = 1'b1;
      repeat (5) @(negedge clk);
      ctl_sample = 1'b0;
      count_done(80, cnt);
      chk(cnt == 0, "R8 R10 no done after abort and boundary rise", cnt, 0);
      chk(result == last_res, "R8 result kept after abort", int'(result), int'(last_res));

      // abort again, rise one cycle after the lockout ends
      start_and_abort(12'h456);
      @(negedge clk) ctl_enable = 1'b1;     // k=1
      repeat (4) @(negedge clk);            // k=5
      ctl_sample = 1'b1;
      @(negedge clk) ctl_sample = 1'b0;
      wait_done(lat);
      chk(result == 12'h456 && lat < 3000, "R10 rise after lockout accepted", int'(result), 'h456);
      last_res = 12'h456;

      // timer source, divider 0
      ctl_trig_sel = 3'b001; ctl_clk_div = 6'd0; vin = 12'h9E7;
      @(negedge clk) ctl_sample = 1'b1;
      @(negedge clk) timer_evt = 1'b1;
      @(negedge clk) timer_evt = 1'b0;
      wait_done(lat);
      chk(lat == 14 + 2, "R7 timer start latency", lat, 16);
      chk(result == 12'h9E7, "R2 timer result", int'(result), 'h9E7);
      @(negedge clk) ctl_sample = 1'b0;

      // external source, divider 1, second event inside the conversion
      ctl_trig_sel = 3'b010; ctl_clk_div = 6'd1; vin = 12'h3A5;
      @(negedge clk) ctl_sample = 1'b1;
      @(negedge clk) ext_evt = 1'b1;
      @(negedge clk) ext_evt = 1'b0;
      repeat (8) @(negedge clk);
      ext_evt = 1'b1;
      @(negedge clk) ext_evt = 1'b0;
      wait_done(lat);
      chk(9 + lat == 14 * 2 + 2, "R7 event during conversion ignored", 9 + lat, 30);
      chk(result == 12'h3A5, "R2 external result", int'(result), 'h3A5);
      @(negedge clk) ctl_sample = 1'b0;
      last_res = 12'h3A5;

      // unused selector code
      ctl_trig_sel = 3'b011; ctl_clk_div = 6'd0; vin = 12'h111;
      @(negedge clk) ctl_sample = 1'b1;
      @(negedge clk) timer_evt = 1'b1;
      @(negedge clk) begin timer_evt = 1'b0; ext_evt = 1'b1; end
      @(negedge clk) ext_evt = 1'b0;
      repeat (4) @(negedge clk);
      ctl_sample = 1'b0;
      count_done(60, cnt);
      chk(cnt == 0, "R2 unused code starts nothing", cnt, 0);
      chk(result == last_res, "R2 result kept for unused code", int'(result), int'(last_res));

      // single-cycle done pulse
      run_sw(6'd0, 12'h2D2, lat);
      @(negedge clk);
      chk(result_done == 1'b0, "R11 done lasts one cycle", int'(result_done), 0);
      chk(result == 12'h2D2, "R11 result held after done", int'(result), 'h2D2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule